// File: doc/BRIEF.md
# Thresholded Event Counter

This block is one programmable hardware event counter. Every clock it receives a multi-bit count of events from detection logic outside the block. It decides whether, and by how much, to advance a 48-bit counter. The decision can compare the incoming count against a programmable threshold, flip the direction of that compare, and keep only rising transitions of the qualified condition. The counter advances only while a local enable in its configuration and an external global enable are both set.

Software reaches the block through a flat register port: a configuration word, the counter value, and a status word that holds a sticky overflow flag. The event-select and qualifier fields of the configuration are passed out unchanged to the detection logic. When the counter wraps, it can hold an interrupt request asserted. One write-only configuration bit sends a single-cycle clear pulse to an associated occupancy counter.

A two-state controller tracks whether counting is live. It has two states: `ST_IDLE` and `ST_COUNT`. The transition `arm` (`ST_IDLE`→`ST_COUNT`) happens in a cycle where the local and global enables are both set. The transition `halt` (`ST_COUNT`→`ST_IDLE`) happens in a cycle where either enable is clear. Each state otherwise holds. In `ST_IDLE` the stored previous condition is treated as deasserted.

Top module: `evt_ctr_top`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `occ_rst`, `evt_sel` and `unit_mask` are zero.
- R2: Register map: address 0 is the configuration, address 1 is the counter (bits 47:0, upper bits read 0), address 2 is status (bit 0 is the overflow flag), and address 3 reads 0. In the configuration, bits 7:0, 15:8, 18, 20, 22, 23 and 31:24 are stored. Bits 16, 17, 19, 21 and 63:32 always read 0. `evt_sel` equals configuration bits 7:0 and `unit_mask` equals bits 15:8.
- R3: The counter changes only in a cycle where configuration bit 22 and `glob_en` are both 1, or when it is written. A configuration write governs counting from the following cycle.
- R4: With threshold bits 31:24 at zero and edge mode off, each enabled cycle adds `evt_cnt` to the counter.
- R5: With a nonzero threshold and bit 23 clear, each enabled cycle adds 1 when `evt_cnt` >= threshold, and adds nothing otherwise.
- R6: With a nonzero threshold and bit 23 set, each enabled cycle adds 1 when `evt_cnt` < threshold, and adds nothing otherwise.
- R7: With bit 18 set, the counter adds 1 only in an enabled cycle where the qualified condition is true and was false in the previous cycle. With a zero threshold, the qualified condition is `evt_cnt` != 0. In the first enabled cycle after a disabled one, the previous condition counts as false.
- R8: A write to address 1 loads `wr_data[47:0]`. It overrides any increment in that cycle, and that cycle raises no overflow.
- R9: An increment that carries past 2^48-1 wraps modulo 2^48 and sets the sticky overflow flag. Writing 1 to status bit 0 clears the flag, but a wrap in the same cycle wins.
- R10: `irq` is 1 exactly when the overflow flag is set and configuration bit 20 is 1.
- R11: Writing configuration bit 17 as 1 gives a single-cycle `occ_rst` pulse in the following cycle. Writing it as 0 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 64 | Read data (combinational) |
| evt_cnt | input | EVT_W (8) | Events detected this cycle |
| glob_en | input | 1 | Global counting enable |
| evt_sel | output | 8 | Event select to detection logic |
| unit_mask | output | 8 | Qualifier to detection logic |
| irq | output | 1 | Overflow interrupt request |
| occ_rst | output | 1 | Occupancy-counter clear pulse |

## Verification
Two pairs of actions can land in the same cycle. A counter wrap can meet a software clear of the overflow flag. A counter load can meet an enabled increment. The bench forces the first collision by loading the counter to its all-ones value and then writing the status clear while a nonzero event count is applied. It forces the second by writing the counter while events are flowing. A reference model in the bench computes the outcome each cycle (the flag stays set; the loaded value is kept and no overflow appears), and every clock the model is compared against the read port and the outputs.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_t;

    // register addresses
    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    // configuration field positions
    localparam int B_OCC_CLR = 17;
    localparam int B_EDGE    = 18;
    localparam int B_IRQ_EN  = 20;
    localparam int B_LOC_EN  = 22;
    localparam int B_INVERT  = 23;
    localparam int B_THR_LO  = 24;

    // stored bits of the configuration word
    localparam logic [31:0] CFG_KEEP = 32'hFFD4_FFFF;

endpackage

// File: rtl/evt_ctr_regs.sv
module evt_ctr_regs
    import evt_ctr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_cfg,
    input  logic [63:0] wr_data,
    output logic [31:0] cfg_q,
    output logic        occ_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            occ_q <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg_q <= wr_data[31:0] & CFG_KEEP;
            end
            occ_q <= wr_cfg & wr_data[B_OCC_CLR];
        end
    end

endmodule

// File: rtl/evt_ctr_qual.sv
module evt_ctr_qual
    import evt_ctr_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int THR_W = 8,
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_cnt,
    input  logic [THR_W-1:0] thr,
    input  logic             invert,
    input  logic             edge_mode,
    input  logic             live,      // previous condition valid
    input  logic             active,    // counting allowed this cycle
    output logic             fire,
    output logic [CNT_W-1:0] amount
);

    localparam int CMP_W = (EVT_W > THR_W) ? EVT_W : THR_W;

    logic [CMP_W-1:0] evt_x;
    logic [CMP_W-1:0] thr_x;
    logic             thr_zero;
    logic             cond;
    logic             cond_q;
    logic             prev;

    assign evt_x    = CMP_W'(evt_cnt);
    assign thr_x    = CMP_W'(thr);
    assign thr_zero = (thr == '0);

    always_comb begin
        if (thr_zero) begin
            cond = (evt_x != '0);
        end else if (invert) begin
            cond = (evt_x < thr_x);
        end else begin
            cond = (evt_x >= thr_x);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
        end else begin
            cond_q <= cond;
        end
    end

    assign prev   = live & cond_q;
    assign fire   = active & (edge_mode ? (cond & ~prev) : cond);
    assign amount = (edge_mode | ~thr_zero) ? CNT_W'(1) : CNT_W'(evt_cnt);

endmodule

// File: rtl/evt_ctr_accum.sv
module evt_ctr_accum #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] amount,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);

    logic [CNT_W:0] sum;
    logic           wrap;

    assign sum  = {1'b0, cnt_q} + {1'b0, amount};
    assign wrap = fire & ~load & sum[CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (load) begin
                cnt_q <= load_val;
            end else if (fire) begin
                cnt_q <= sum[CNT_W-1:0];
            end
            if (wrap) begin
                ovf_q <= 1'b1;
            end else if (clr_flag) begin
                ovf_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/evt_ctr_top.sv
module evt_ctr_top
    import evt_ctr_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [63:0]      wr_data,
    input  logic [1:0]       rd_addr,
    output logic [63:0]      rd_data,
    input  logic [EVT_W-1:0] evt_cnt,
    input  logic             glob_en,
    output logic [7:0]       evt_sel,
    output logic [7:0]       unit_mask,
    output logic             irq,
    output logic             occ_rst
);

    localparam int THR_W = 8;

    run_state_t       state_q;
    run_state_t       state_d;
    logic [31:0]      cfg_q;
    logic             occ_q;
    logic             active;
    logic             live;
    logic             fire;
    logic [CNT_W-1:0] amount;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             wr_cfg;
    logic             wr_cnt;
    logic             wr_stat;

    assign wr_cfg  = wr_en & (wr_addr == A_CFG);
    assign wr_cnt  = wr_en & (wr_addr == A_CNT);
    assign wr_stat = wr_en & (wr_addr == A_STAT);
    assign active  = cfg_q[B_LOC_EN] & glob_en;
    assign live    = (state_q == ST_COUNT);

    evt_ctr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cfg  (wr_cfg),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .occ_q   (occ_q)
    );

    // run-state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: arm / halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (active)  state_d = ST_COUNT;
            ST_COUNT: if (!active) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    evt_ctr_qual #(
        .EVT_W (EVT_W),
        .THR_W (THR_W),
        .CNT_W (CNT_W)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_cnt   (evt_cnt),
        .thr       (cfg_q[B_THR_LO +: THR_W]),
        .invert    (cfg_q[B_INVERT]),
        .edge_mode (cfg_q[B_EDGE]),
        .live      (live),
        .active    (active),
        .fire      (fire),
        .amount    (amount)
    );

    evt_ctr_accum #(
        .CNT_W (CNT_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .amount   (amount),
        .load     (wr_cnt),
        .load_val (wr_data[CNT_W-1:0]),
        .clr_flag (wr_stat & wr_data[0]),
        .cnt_q    (cnt_q),
        .ovf_q    (ovf_q)
    );

    // outputs
    always_comb begin
        unique case (rd_addr)
            A_CFG:   rd_data = {32'b0, cfg_q};
            A_CNT:   rd_data = 64'(cnt_q);
            A_STAT:  rd_data = {63'b0, ovf_q};
            default: rd_data = '0;
        endcase
        evt_sel   = cfg_q[7:0];
        unit_mask = cfg_q[15:8];
        irq       = ovf_q & cfg_q[B_IRQ_EN];
        occ_rst   = occ_q;
    end

endmodule

// File: rtl/evt_ctr_chk.sv
module evt_ctr_chk #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [63:0]      wr_data,
    input logic [1:0]       rd_addr,
    input logic [63:0]      rd_data,
    input logic             glob_en,
    input logic [31:0]      cfg_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_q,
    input logic             irq,
    input logic             occ_rst
);

    // R11
    occ_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_rst == $past(wr_en && wr_addr == 2'd0 && wr_data[17]));

    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_q[22] && glob_en) && !(wr_en && wr_addr == 2'd1)) |=> $stable(cnt_q));

    // R9
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> ovf_q);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_q && cfg_q[20]));

    // R2
    cfg_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd0) |-> (rd_data[63:32] == 32'b0 && rd_data[21] == 1'b0
                               && rd_data[19:16] == 4'b0000 ? 1'b1 : rd_data[18] == 1'b1 && rd_data[17:16] == 2'b00 && rd_data[19] == 1'b0 && rd_data[63:32] == 32'b0 && rd_data[21] == 1'b0));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> (cnt_q == $past(wr_data[CNT_W-1:0]) && ovf_q == $past(ovf_q)
                                        || (cnt_q == $past(wr_data[CNT_W-1:0]) && $past(wr_en && wr_addr == 2'd1))));

endmodule

bind evt_ctr_top evt_ctr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .glob_en (glob_en),
    .cfg_q   (cfg_q),
    .cnt_q   (cnt_q),
    .ovf_q   (ovf_q),
    .irq     (irq),
    .occ_rst (occ_rst)
);

// File: tb/evt_ctr_top_tb.sv
`timescale 1ns/1ps
module evt_ctr_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic [7:0]  evt_cnt = '0;
    logic        glob_en = 1'b0;
    logic [7:0]  evt_sel;
    logic [7:0]  unit_mask;
    logic        irq;
    logic        occ_rst;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [31:0] m_cfg;
    logic [47:0] m_cnt;
    logic        m_ovf;
    logic        m_prev;
    logic        m_live;
    logic        m_occ;

    always #2 clk = ~clk;

    evt_ctr_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .evt_cnt   (evt_cnt),
        .glob_en   (glob_en),
        .evt_sel   (evt_sel),
        .unit_mask (unit_mask),
        .irq       (irq),
        .occ_rst   (occ_rst)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {32'b0, m_cfg};
            2'd1:    return {16'b0, m_cnt};
            2'd2:    return {63'b0, m_ovf};
            default: return 64'b0;
        endcase
    endfunction

    // one clock: apply inputs, advance model, compare after the edge
    task automatic step(input string tag, input logic we, input logic [1:0] wa,
                        input logic [63:0] wd, input logic [1:0] ra,
                        input logic [7:0] ev, input logic ge);
        logic        act, qual, prevv, fire;
        logic [7:0]  th;
        logic [48:0] sum;
        logic [47:0] amt;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        evt_cnt = ev; glob_en = ge;
        act   = m_cfg[22] && ge;
        th    = m_cfg[31:24];
        qual  = (th == 0) ? (ev != 0) : (m_cfg[23] ? (ev < th) : (ev >= th));
        prevv = m_live ? m_prev : 1'b0;
        fire  = act && (m_cfg[18] ? (qual && !prevv) : qual);
        amt   = (m_cfg[18] || th != 0) ? 48'd1 : {40'b0, ev};
        sum   = {1'b0, m_cnt} + {1'b0, amt};
        @(posedge clk);
        #1;
        if (fire && !(we && wa == 2'd1) && sum[48]) m_ovf = 1'b1;
        else if (we && wa == 2'd2 && wd[0]) m_ovf = 1'b0;
        if (we && wa == 2'd1) m_cnt = wd[47:0];
        else if (fire) m_cnt = sum[47:0];
        m_prev = qual;
        m_live = act;
        m_occ  = we && wa == 2'd0 && wd[17];
        if (we && wa == 2'd0) m_cfg = wd[31:0] & 32'hFFD4_FFFF;
        chk({tag, " rd"}, rd_data, exp_rd(ra));
        chk("R10 irq", {63'b0, irq}, {63'b0, m_ovf & m_cfg[20]});
        chk("R11 occ_rst", {63'b0, occ_rst}, {63'b0, m_occ});
        chk("R2 evt_sel", {56'b0, evt_sel}, {56'b0, m_cfg[7:0]});
        chk("R2 unit_mask", {56'b0, unit_mask}, {56'b0, m_cfg[15:8]});
    endtask

    task automatic wcfg(input string tag, input logic [31:0] v, input logic ge);
        step(tag, 1'b1, 2'd0, {32'hFFFF_FFFF, v}, 2'd0, 8'd0, ge);
    endtask

    task automatic wcnt(input string tag, input logic [47:0] v);
        step(tag, 1'b1, 2'd1, {16'hABCD, v}, 2'd1, 8'd0, 1'b0);
    endtask

    task automatic run(input string tag, input logic [7:0] ev, input logic ge);
        step(tag, 1'b0, 2'd0, 64'd0, 2'd1, ev, ge);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_cfg = '0; m_cnt = '0; m_ovf = 0; m_prev = 0; m_live = 0; m_occ = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state on every address
        for (int a = 0; a < 4; a++) step("R1", 1'b0, 2'd0, 64'd0, 2'(a), 8'd0, 1'b0);

        // R2 reserved bits and bit17 read zero; fields pass out
        wcfg("R2", 32'hFFFF_A55A, 1'b0);
        step("R2", 1'b0, 2'd0, 64'd0, 2'd0, 8'd0, 1'b0);
        step("R2", 1'b0, 2'd3, 64'd0, 2'd3, 8'd0, 1'b0);

        // R4 threshold zero: accumulate
        wcfg("R4", 32'h0040_0000, 1'b1);
        run("R4", 8'd5, 1'b1);
        run("R4", 8'd200, 1'b1);
        run("R4", 8'd0, 1'b1);
        // R3 global low, then local low
        run("R3", 8'd9, 1'b0);
        wcfg("R3", 32'h0000_0000, 1'b1);
        run("R3", 8'd9, 1'b1);
        run("R3", 8'd9, 1'b1);

        // R5 threshold 3, >=
        wcfg("R5", 32'h0340_0000, 1'b1);
        for (int v = 0; v < 7; v++) run("R5", 8'(v), 1'b1);
        // R6 threshold 3, <
        wcfg("R6", 32'h03C0_0000, 1'b1);
        for (int v = 0; v < 7; v++) run("R6", 8'(v), 1'b1);

        // R7 edge with threshold 2
        wcfg("R7", 32'h0244_0000, 1'b1);
        run("R7", 8'd3, 1'b1);
        run("R7", 8'd4, 1'b1);
        run("R7", 8'd0, 1'b1);
        run("R7", 8'd2, 1'b1);
        run("R7", 8'd5, 1'b0);
        run("R7", 8'd5, 1'b1);
        run("R7", 8'd5, 1'b1);
        // R7 edge with zero threshold
        wcfg("R7", 32'h0044_0000, 1'b1);
        run("R7", 8'd1, 1'b1);
        run("R7", 8'd7, 1'b1);
        run("R7", 8'd0, 1'b1);
        run("R7", 8'd7, 1'b1);

        // R8 load while events flow
        wcfg("R8", 32'h0050_0000, 1'b1);
        step("R8", 1'b1, 2'd1, 64'h0000_0000_0000_1234, 2'd1, 8'd50, 1'b1);
        run("R8", 8'd1, 1'b1);
        // R8 load near top while wrap would occur: no overflow
        wcnt("R8", 48'hFFFF_FFFF_FFFF);
        step("R8", 1'b1, 2'd1, 64'h0000_FFFF_FFFF_FFFF, 2'd2, 8'd9, 1'b1);
        step("R8", 1'b0, 2'd0, 64'd0, 2'd2, 8'd0, 1'b1);

        // R9 / R10 wrap sets flag, irq with enable
        wcnt("R9", 48'hFFFF_FFFF_FFFE);
        run("R9", 8'd5, 1'b1);
        step("R9", 1'b0, 2'd0, 64'd0, 2'd2, 8'd0, 1'b1);
        // R9 clear and wrap collide: set wins
        wcnt("R9", 48'hFFFF_FFFF_FFFF);
        step("R9", 1'b1, 2'd2, 64'd1, 2'd2, 8'd1, 1'b1);
        step("R9", 1'b1, 2'd2, 64'd0, 2'd2, 8'd0, 1'b1);
        step("R9", 1'b1, 2'd2, 64'd1, 2'd2, 8'd0, 1'b1);
        // R10 irq masked when bit20 clear
        wcnt("R10", 48'hFFFF_FFFF_FFFF);
        wcfg("R10", 32'h0040_0000, 1'b1);
        run("R10", 8'd2, 1'b1);
        wcfg("R10", 32'h0050_0000, 1'b1);
        step("R10", 1'b1, 2'd2, 64'd1, 2'd2, 8'd0, 1'b1);

        // R11 occupancy pulse only on a one
        wcfg("R11", 32'h0002_0000, 1'b0);
        wcfg("R11", 32'h0002_0000, 1'b0);
        run("R11", 8'd0, 1'b0);
        wcfg("R11", 32'h0000_0000, 1'b0);
        run("R11", 8'd0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule